// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that gives a host access to a small bank of 8-bit control registers. The host drives a serial clock, an active-low select and a data line. Each transaction opens with an instruction byte and continues with any number of data bytes. The instruction byte carries a read/write flag and a start address, and the address steps up by one after every data byte. Bytes are assembled on rising serial clock edges. Each byte is committed on its eighth edge, and the bit counter starts again every time the select asserts.

Bit order and line mode are not fixed. They are held in register 0 and take effect from the next byte. In 3-wire mode read data comes back on the shared data line, with an output-enable for the pad. In 4-wire mode the data line only receives, and read data leaves on a separate output pin. In both modes read data changes on the falling serial clock edge.

The bank has a self-clearing software reset, a pending offset-correction request that clears when a done input arrives, and a live read-only calibration-busy flag. Power-down, clock-multiplier and filter settings are decoded onto output pins for the analog blocks, which lie outside this block. The serial inputs are resynchronised to the system clock.

Top module: `spi_cfg_slave`

## Requirements
- R1: A byte is complete on the 8th rising serial clock edge counted since the select last went low. The first byte of a transaction is the instruction: bit 7 = 1 means read, bit 7 = 0 means write, and bits 6:0 give the start address, taken modulo the number of registers.
- R2: In a multibyte access the address steps up by one after each data byte. In a write, each register is updated as soon as its own byte completes, before the next byte finishes. A read returns the stored value of every register.
- R3: Register 0 bit 6 sets the bit order for all bytes, instruction bytes included, in both directions. 0 means most significant bit first and 1 means least significant bit first.
- R4: Register 0 bit 7 = 1 selects 4-wire mode: read data appears on sdoOut and sdioOe is never asserted. In 3-wire mode (bit 7 = 0), sdioOe is high while read data bytes are being sent.
- R5: Read data changes only after a falling serial clock edge and holds steady while the serial clock is high.
- R6: Writing a 1 to register 0 bit 5 is a software reset. All registers return to 0, except register 0 bit 6, which keeps the value written in that same byte. Bit 5 then reads 0, and the port drops back to 3-wire mode.
- R7: Register 1 bits 5:0 appear on pwrDown[5:0], one bit each.
- R8: Register 3 bits 1:0 select pllFactor: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. Register 3 bit 6 drives adcClkDiv2, and register 4 bits 4:0 drive rxFiltCtrl.
- R9: Writing a 1 to register 4 bit 5 raises offsetReq, which register 4 bit 5 reads back. Writing a 0 there does not cancel the request. A pulse on offsetDone clears it.
- R10: Register 4 bit 6 always reads the calBusy input, and writes to that bit have no effect.
- R11: Raising the select in the middle of a byte discards that partial byte and leaves all registers unchanged. The next transaction decodes normally.
- R12: After reset every register reads 0, pllFactor is 1 and sdioOe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| senN | input | 1 | Active-low transaction select |
| sdioIn | input | 1 | Serial data from the host |
| sdioOut | output | 1 | Read data driven onto the shared data line in 3-wire mode |
| sdioOe | output | 1 | Output enable for the shared data line |
| sdoOut | output | 1 | Dedicated read-data pin in 4-wire mode |
| calBusy | input | 1 | Calibration-in-progress status |
| offsetDone | input | 1 | Pulse that completes an offset-correction request |
| pwrDown | output | 6 | Power-down controls |
| pllFactor | output | 4 | Decoded clock multiplier (1, 2, 4 or 8) |
| adcClkDiv2 | output | 1 | Divide-by-2 sampling-clock select |
| rxFiltCtrl | output | 5 | Receive filter control bits |
| offsetReq | output | 1 | Pending offset-correction request |

## Verification
Writes and reads are run in all four combinations of bit order and line mode. The test values are not symmetric under bit reversal, so a port that used the wrong bit order or read the wrong pin would return visibly different bytes. A long write is paused after each byte to show that each register changes before the next byte completes. An aborted half byte followed by a clean transaction shows that the bit counter restarts on select. The software reset, offset request and busy flag are driven from several starting states, so that bits which are kept can be told apart from bits which are cleared.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int INSTR_ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic                    wrEn;
    logic [INSTR_ADDR_W-1:0] wrAddr;
    logic [BYTE_W-1:0]       wrData;
  } wrStrobe_t;
endpackage

// File: rtl/spi_cfg_serial.sv
module spi_cfg_serial
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    senN,
  input  logic                    sdioIn,
  input  logic                    lsbFirst,
  input  logic                    fourWire,
  input  logic [BYTE_W-1:0]       rdData,
  output wrStrobe_t               strb,
  output logic [INSTR_ADDR_W-1:0] rdAddr,
  output logic                    sdioOut,
  output logic                    sdioOe,
  output logic                    sdoOut
);
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] senPipe;
  logic [SYNC_STAGES-1:0] dinPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      senPipe  <= '1;
      dinPipe  <= '0;
    end else begin
      sclkPipe <= (SYNC_STAGES+1)'({sclkPipe, sclk});
      senPipe  <= SYNC_STAGES'({senPipe, senN});
      dinPipe  <= SYNC_STAGES'({dinPipe, sdioIn});
    end
  end

  logic active, sclkRise, sclkFall, din;
  assign active   = !senPipe[SYNC_STAGES-1];
  assign sclkRise = active && sclkPipe[SYNC_STAGES-1] && !sclkPipe[SYNC_STAGES];
  assign sclkFall = active && !sclkPipe[SYNC_STAGES-1] && sclkPipe[SYNC_STAGES];
  assign din      = dinPipe[SYNC_STAGES-1];

  logic [2:0]              bitCnt;
  logic                    firstByte;
  logic                    isRead;
  logic                    loadPend;
  logic                    outBit;
  logic [INSTR_ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0]       shIn;
  logic [BYTE_W-1:0]       txByte;
  logic [BYTE_W-1:0]       nextSh;
  logic [2:0]              outIdx;
  logic                    byteDone;

  always_comb begin
    nextSh   = lsbFirst ? {din, shIn[BYTE_W-1:1]} : {shIn[BYTE_W-2:0], din};
    outIdx   = lsbFirst ? bitCnt : 3'd7 - bitCnt;
    byteDone = sclkRise && (bitCnt == 3'd7);
  end

  assign strb.wrEn   = byteDone && !firstByte && !isRead;
  assign strb.wrAddr = addrQ;
  assign strb.wrData = nextSh;
  assign rdAddr      = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      firstByte <= 1'b1;
      isRead    <= 1'b0;
      loadPend  <= 1'b0;
      addrQ     <= '0;
      shIn      <= '0;
      txByte    <= '0;
    end else if (!active) begin
      bitCnt    <= '0;
      firstByte <= 1'b1;
      isRead    <= 1'b0;
      loadPend  <= 1'b0;
    end else begin
      if (loadPend) begin
        txByte   <= rdData;
        loadPend <= 1'b0;
      end
      if (sclkRise) begin
        shIn   <= nextSh;
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          if (firstByte) begin
            firstByte <= 1'b0;
            isRead    <= nextSh[BYTE_W-1];
            addrQ     <= nextSh[INSTR_ADDR_W-1:0];
            loadPend  <= nextSh[BYTE_W-1];
          end else begin
            addrQ    <= addrQ + 1'b1;
            loadPend <= isRead;
          end
        end
      end
    end
  end

  // read data moves only on falling serial clock edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBit <= 1'b0;
    else if (sclkFall) outBit <= (isRead && !firstByte) ? txByte[outIdx] : 1'b0;
  end

  assign sdioOut = outBit;
  assign sdoOut  = outBit;
  assign sdioOe  = active && isRead && !firstByte && !fourWire;

  AST_WRITE_ENDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (bitCnt == 3'd0)); // R1
  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == 3'd0 && firstByte)); // R11
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !sclkFall |=> $stable(outBit)); // R5
  AST_NO_OE_4WIRE: assert property (@(posedge clk) disable iff (!rstN)
    fourWire |-> !sdioOe); // R4
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8   // power of two, at least 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wrStrobe_t               strb,
  input  logic [INSTR_ADDR_W-1:0] rdAddr,
  input  logic                    calBusy,
  input  logic                    offsetDone,
  output logic [BYTE_W-1:0]       rdData,
  output logic                    lsbFirst,
  output logic                    fourWire,
  output logic [5:0]              pwrDown,
  output logic [3:0]              pllFactor,
  output logic                    adcClkDiv2,
  output logic [4:0]              rxFiltCtrl,
  output logic                    offsetReq
);
  localparam int ADDR_W = $clog2(NUM_REGS);

  logic [ADDR_W-1:0] wrIdx, rdIdx;
  logic              unusedAddrHi;
  assign wrIdx        = strb.wrAddr[ADDR_W-1:0];
  assign rdIdx        = rdAddr[ADDR_W-1:0];
  assign unusedAddrHi = ^{strb.wrAddr[INSTR_ADDR_W-1:ADDR_W], rdAddr[INSTR_ADDR_W-1:ADDR_W]};

  logic swResetPend;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swResetPend <= 1'b0;
    else       swResetPend <= strb.wrEn && (wrIdx == '0) && strb.wrData[5];
  end

  logic [NUM_REGS-1:0][BYTE_W-1:0] bankVal;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic              hit;
    assign hit = strb.wrEn && (wrIdx == ADDR_W'(i));

    if (i == 0) begin : g_ctl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            q <= '0;
        else if (swResetPend) q <= {1'b0, q[6], 6'b0};
        else if (hit)         q <= strb.wrData;
      end
    end else if (i == 4) begin : g_rx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            q <= '0;
        else if (swResetPend) q <= '0;
        else begin
          if (hit) q <= {strb.wrData[7], 2'b00, strb.wrData[4:0]};
          q[5] <= (hit && strb.wrData[5]) || (q[5] && !offsetDone);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            q <= '0;
        else if (swResetPend) q <= '0;
        else if (hit)         q <= strb.wrData;
      end
    end
    assign bankVal[i] = q;
  end

  always_comb begin
    rdData = bankVal[rdIdx];
    if (rdIdx == ADDR_W'(4)) rdData[6] = calBusy;
  end

  assign lsbFirst   = bankVal[0][6];
  assign fourWire   = bankVal[0][7];
  assign pwrDown    = bankVal[1][5:0];
  assign pllFactor  = 4'b0001 << bankVal[3][1:0];
  assign adcClkDiv2 = bankVal[3][6];
  assign rxFiltCtrl = bankVal[4][4:0];
  assign offsetReq  = bankVal[4][5];

  AST_SWRST_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && wrIdx == '0 && strb.wrData[5]) |=> ##1
      (bankVal[1] == '0 && !bankVal[0][5] && !bankVal[0][7] &&
       bankVal[0][6] == $past(strb.wrData[6], 2))); // R6
  AST_OFFSET_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (offsetReq && !offsetDone && !swResetPend) |=> offsetReq); // R9
  AST_OFFSET_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (offsetReq && offsetDone && !(strb.wrEn && wrIdx == ADDR_W'(4) && strb.wrData[5]))
      |=> !offsetReq); // R9
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       senN,
  input  logic       sdioIn,
  output logic       sdioOut,
  output logic       sdioOe,
  output logic       sdoOut,
  input  logic       calBusy,
  input  logic       offsetDone,
  output logic [5:0] pwrDown,
  output logic [3:0] pllFactor,
  output logic       adcClkDiv2,
  output logic [4:0] rxFiltCtrl,
  output logic       offsetReq
);
  wrStrobe_t               strb;
  logic [INSTR_ADDR_W-1:0] rdAddr;
  logic [BYTE_W-1:0]       rdData;
  logic                    lsbFirst, fourWire;

  spi_cfg_serial #(.SYNC_STAGES(SYNC_STAGES)) u_serial (
    .clk(clk), .rstN(rstN), .sclk(sclk), .senN(senN), .sdioIn(sdioIn),
    .lsbFirst(lsbFirst), .fourWire(fourWire), .rdData(rdData),
    .strb(strb), .rdAddr(rdAddr),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut)
  );

  spi_cfg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr),
    .calBusy(calBusy), .offsetDone(offsetDone), .rdData(rdData),
    .lsbFirst(lsbFirst), .fourWire(fourWire), .pwrDown(pwrDown),
    .pllFactor(pllFactor), .adcClkDiv2(adcClkDiv2),
    .rxFiltCtrl(rxFiltCtrl), .offsetReq(offsetReq)
  );
endmodule

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclk, senN, sdioIn, calBusy, offsetDone;
  logic sdioOut, sdioOe, sdoOut, adcClkDiv2, offsetReq;
  logic [5:0] pwrDown;
  logic [3:0] pllFactor;
  logic [4:0] rxFiltCtrl;

  spi_cfg_slave u_spi_cfg_slave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .senN(senN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut),
    .calBusy(calBusy), .offsetDone(offsetDone), .pwrDown(pwrDown),
    .pllFactor(pllFactor), .adcClkDiv2(adcClkDiv2),
    .rxFiltCtrl(rxFiltCtrl), .offsetReq(offsetReq)
  );

  int tests = 0, fails = 0, monFails = 0;
  bit finished = 0;
  bit cmpEn = 0;
  bit lsbM = 0, fourM = 0;
  logic [7:0] mdl [8];

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model of the bank
  task automatic modelWrite(input int a, input logic [7:0] d);
    if (a == 0 && d[5]) begin
      for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
      mdl[0] = d & 8'h40;
      lsbM = d[6];
      fourM = 1'b0;
    end else if (a == 0) begin
      mdl[0] = d; lsbM = d[6]; fourM = d[7];
    end else if (a == 4) begin
      mdl[4] = {d[7], 1'b0, mdl[4][5] | d[5], d[4:0]};
    end else begin
      mdl[a] = d;
    end
  endtask

  function automatic logic [7:0] modelRead(input int a);
    logic [7:0] v;
    v = mdl[a];
    if (a == 4) v[6] = calBusy;
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmpEn && !finished) begin
      tests++;
      if (pwrDown !== mdl[1][5:0] || pllFactor !== (4'b0001 << mdl[3][1:0]) ||
          adcClkDiv2 !== mdl[3][6] || rxFiltCtrl !== mdl[4][4:0] ||
          offsetReq !== mdl[4][5]) begin
        fails++;
        monFails++;
        if (monFails < 8)
          $display("FAIL R7/R8/R9 outputs actual=%h/%h/%b/%h/%b expected=%h/%h/%b/%h/%b",
                   pwrDown, pllFactor, adcClkDiv2, rxFiltCtrl, offsetReq,
                   mdl[1][5:0], 4'b0001 << mdl[3][1:0], mdl[3][6], mdl[4][4:0], mdl[4][5]);
      end
    end
  end

  task automatic spiBit(input bit b, output bit r, output bit ok);
    logic v1, v2;
    sdioIn = b;
    clks(HALF);
    r = fourM ? sdoOut : sdioOut;
    sclk = 1'b1;
    clks(2);
    v1 = fourM ? sdoOut : sdioOut;
    clks(HALF - 2);
    v2 = fourM ? sdoOut : sdioOut;
    ok = (v1 === r) && (v2 === r);
    sclk = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, output bit stab);
    bit r, ok;
    cmpEn = 0;
    stab = 1;
    rx = 8'h00;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsbM ? i : 7 - i;
      spiBit(tx[idx], r, ok);
      rx[idx] = r;
      stab &= ok;
    end
  endtask

  task automatic startTx;
    sclk = 1'b0;
    senN = 1'b0;
    clks(HALF);
  endtask

  task automatic endTx;
    clks(HALF);
    senN = 1'b1;
    clks(2 * HALF);
    cmpEn = 1;
  endtask

  task automatic writeRegs(input int addr, input logic [7:0] d0, input int n,
                           input logic [7:0] d1 = 0, input logic [7:0] d2 = 0);
    logic [7:0] rx, dat;
    bit st;
    int a;
    a = addr;
    startTx();
    spiByte(8'(addr), rx, st);
    for (int k = 0; k < n; k++) begin
      dat = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      spiByte(dat, rx, st);
      modelWrite(a, dat);
      a = (a + 1) % 8;
      cmpEn = 1;
    end
    endTx();
  endtask

  task automatic readRegs(input int addr, input int n, input string req);
    logic [7:0] rx;
    bit st;
    int a;
    a = addr;
    startTx();
    spiByte(8'h80 | 8'(addr), rx, st);
    for (int k = 0; k < n; k++) begin
      spiByte(8'h00, rx, st);
      check(req, rx, modelRead(a));
      check("R5 stable while sclk high", st, 1);
      check("R4 output enable", sdioOe, fourM ? 0 : 1);
      a = (a + 1) % 8;
    end
    endTx();
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [7:0] rx;
    bit st, r, ok;
    for (int k = 0; k < 8; k++) mdl[k] = 8'h00;
    rstN = 0; sclk = 0; senN = 1; sdioIn = 0; calBusy = 0; offsetDone = 0;
    clks(5);
    rstN = 1;
    clks(3);

    // R12 reset state
    check("R12 pllFactor", pllFactor, 1);
    check("R12 pwrDown", pwrDown, 0);
    check("R12 sdioOe", sdioOe, 0);
    check("R12 offsetReq", offsetReq, 0);
    cmpEn = 1;
    readRegs(0, 8, "R12 default read");

    // R7 single write, MSB first
    writeRegs(1, 8'h2A, 1);
    check("R7 pwrDown", pwrDown, 6'h2A);

    // R2 multibyte write: each register changes before the next byte completes
    startTx();
    spiByte(8'h01, rx, st);
    spiByte(8'h15, rx, st); modelWrite(1, 8'h15);
    check("R2 reg1 committed mid-transaction", pwrDown, 6'h15);
    check("R2 reg3 not yet written", pllFactor, 1);
    spiByte(8'h77, rx, st); modelWrite(2, 8'h77);
    spiByte(8'h02, rx, st); modelWrite(3, 8'h02);
    check("R2 reg3 committed mid-transaction", pllFactor, 4);
    check("R1 R2 rxFiltCtrl untouched before its byte", rxFiltCtrl, 0);
    spiByte(8'h1B, rx, st); modelWrite(4, 8'h1B);
    check("R8 rxFiltCtrl", rxFiltCtrl, 5'h1B);
    endTx();

    // R8 multiplier decode
    for (int c = 0; c < 4; c++) begin
      writeRegs(3, 8'(c) | (c[0] ? 8'h40 : 8'h00), 1);
      check("R8 pllFactor", pllFactor, 1 << c);
      check("R8 adcClkDiv2", adcClkDiv2, c & 1);
    end
    readRegs(0, 5, "R2 readback MSB 3-wire");

    // R3 LSB first
    writeRegs(0, 8'h40, 1);
    writeRegs(2, 8'hC5, 1);
    writeRegs(1, 8'h01, 1);
    check("R3 LSB-first write pwrDown", pwrDown, 6'h01);
    readRegs(2, 1, "R3 LSB-first readback");

    // R4 4-wire, LSB first then MSB first
    writeRegs(0, 8'hC0, 1);
    readRegs(0, 3, "R4 4-wire LSB readback");
    writeRegs(0, 8'h80, 1);
    writeRegs(6, 8'h9E, 1);
    readRegs(6, 2, "R4 4-wire MSB readback");

    // R6 software reset keeps bit order
    writeRegs(0, 8'hC0, 1);
    writeRegs(4, 8'h20, 2, 8'h5A);
    check("R9 offsetReq raised", offsetReq, 1);
    writeRegs(0, 8'hE0, 1);
    check("R6 offsetReq cleared", offsetReq, 0);
    check("R6 pllFactor restored", pllFactor, 1);
    readRegs(0, 8, "R6 after software reset");

    // R9 offset correction request
    writeRegs(4, 8'h20, 1);
    check("R9 offsetReq", offsetReq, 1);
    readRegs(4, 1, "R9 pending readback");
    writeRegs(4, 8'h00, 1);
    check("R9 write 0 keeps request", offsetReq, 1);
    cmpEn = 0;
    offsetDone = 1; clks(1); offsetDone = 0;
    mdl[4][5] = 1'b0;
    clks(1);
    cmpEn = 1;
    check("R9 done clears", offsetReq, 0);
    readRegs(4, 1, "R9 cleared readback");

    // R10 read-only status bit
    writeRegs(4, 8'h40, 1);
    readRegs(4, 1, "R10 write ignored");
    calBusy = 1;
    clks(2);
    readRegs(4, 1, "R10 busy shown");
    writeRegs(4, 8'h00, 1);
    readRegs(4, 1, "R10 busy after write 0");
    calBusy = 0;

    // R11 abort mid-byte
    writeRegs(2, 8'h33, 1);
    startTx();
    spiByte(8'h02, rx, st);
    for (int i = 0; i < 4; i++) spiBit(1'b1, r, ok);
    clks(HALF);
    senN = 1'b1;
    clks(2 * HALF);
    cmpEn = 1;
    writeRegs(6, 8'h3C, 1);
    readRegs(2, 1, "R11 partial byte discarded");
    readRegs(6, 1, "R11 next transaction decodes");

    clks(10);
    finish();
  end
endmodule